// File: doc/BRIEF.md
# Serial Byte Receiver with Idle-Line Event

This block receives asynchronous serial characters from a single RX wire and hands each byte to the logic behind it. A character is ten bit times long: one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. The line is passed through a two-flop synchroniser. It is then sampled on a grid of sixteen sub-bit steps per bit, with a parameterised number of clocks per step. Each byte appears with a single-cycle valid strobe. A per-byte framing-error flag travels with that strobe.

The block also reports bursts whose length is not known in advance. Once at least one byte has arrived, the block watches for a full character time of quiet high line. When it sees one, it emits a single idle pulse. A consumer that moves bytes in fixed-size chunks can use this pulse to collect the short tail of a burst. The pulse fires once per burst. Any low sample on the line during the countdown restarts it. A new byte must arrive before the pulse can fire again.

Top module: `serial_rx_idle`

## Requirements
- R1: While reset is held low and on the first cycle after it, `rx_valid_o`, `rx_frame_err_o` and `rx_idle_o` are 0. The synchroniser resets to the high (idle) line level.
- R2: Bit period B = CLKS_PER_TICK*OVERSAMPLE clocks and H = B/2. When the RX input first reads low at clock edge k, `rx_valid_o` is high in the cycle after edge k+2+H+9*B. In that cycle `rx_data_o` holds the eight data bits, with the first bit received in bit 0.
- R3: `rx_valid_o` is high for exactly one cycle per received character.
- R4: A start bit that is high again at its mid-bit sample (edge k+2+H) is dropped. No byte is produced, and the receiver resumes hunting for a falling edge.
- R5: `rx_frame_err_o` is 1 together with `rx_valid_o` when the stop bit samples low, and 0 at every other time. The byte is still delivered. After such a byte the receiver waits for the line to go high before it hunts again.
- R6: `rx_idle_o` is a one-cycle pulse. When it has been armed by a byte whose strobe was at edge E, it fires at edge max(E+1, L) + 10*B. L is the last edge at which the synchronised line was low.
- R7: No idle pulse occurs before the first byte after reset. At most one occurs between two bytes.
- R8: A low sample on the synchronised line during the idle countdown restarts the countdown from zero. A dropped start glitch counts as such a sample.
- R9: Characters sent back to back, with the next start bit directly after the stop bit, are all received. Only one idle pulse follows the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte |
| rx_frame_err_o | output | 1 | Stop bit read low, qualified by the strobe |
| rx_idle_o | output | 1 | One-cycle idle-line event after a burst |

## Verification
Counted from the first clock edge that captures a low line, a byte strobe is due 2+H+9*B edges later. The 2 covers the synchroniser, H reaches the start mid-point and 9*B reaches the stop mid-point. The idle pulse is due 10*B edges after the later of the edge following the strobe and the last low sample on the synchronised line. The bench stamps every scheduled character with its due edge. It tracks the last low sample from its own record of the driven line, delayed by two edges. On every falling clock edge it compares strobe, data, error flag and idle pulse against those stamps, so an early or late result fails in the exact cycle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [2:0] {
    RX_HUNT,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  // clocks in one bit period
  function automatic int unsigned bit_clks(int unsigned div, int unsigned osr);
    return div * osr;
  endfunction

  // clocks from start edge to start mid-point
  function automatic int unsigned half_clks(int unsigned div, int unsigned osr);
    return bit_clks(div, osr) / 2;
  endfunction

  // clocks in one whole character
  function automatic int unsigned char_clks(int unsigned div, int unsigned osr);
    return FRAME_BITS * bit_clks(div, osr);
  endfunction

  // data arrives LSB first: new bit enters at the top
  function automatic logic [DATA_BITS-1:0] shift_in(logic [DATA_BITS-1:0] sr, logic b);
    return {b, sr[DATA_BITS-1:1]};
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (!rst_ni) chain <= '1;
        else         chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (!rst_ni) chain <= '1;
        else         chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 4,
  parameter int unsigned OVERSAMPLE    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_s_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o,
  output logic                 start_glitch_o,
  output logic                 byte_done_o,
  output logic                 stop_low_o
);

  localparam int unsigned BIT_CLKS  = bit_clks(CLKS_PER_TICK, OVERSAMPLE);
  localparam int unsigned HALF_CLKS = half_clks(CLKS_PER_TICK, OVERSAMPLE);
  localparam int unsigned CW        = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned BW        = $clog2(DATA_BITS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CLKS - 1);
  localparam logic [BW-1:0] IDX_LAST  = BW'(DATA_BITS - 1);

  rx_state_e            state;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;

  logic half_hit, bit_hit;
  assign half_hit = (cnt == HALF_LAST);
  assign bit_hit  = (cnt == BIT_LAST);

  assign start_glitch_o = (state == RX_START) && half_hit && rx_s_i;
  assign byte_done_o    = (state == RX_STOP) && bit_hit;
  assign stop_low_o     = byte_done_o && !rx_s_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state       <= RX_HUNT;
      cnt         <= '0;
      bit_idx     <= '0;
      shreg       <= '0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      unique case (state)
        RX_HUNT: begin
          cnt <= '0;
          if (!rx_s_i) state <= RX_START;
        end
        RX_START: begin
          if (half_hit) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rx_s_i ? RX_HUNT : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_hit) begin
            cnt   <= '0;
            shreg <= shift_in(shreg, rx_s_i);
            if (bit_idx == IDX_LAST) state <= RX_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_hit) begin
            cnt         <= '0;
            data_o      <= shreg;
            valid_o     <= 1'b1;
            frame_err_o <= !rx_s_i;
            state       <= rx_s_i ? RX_HUNT : RX_BREAK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BREAK: begin
          cnt <= '0;
          if (rx_s_i) state <= RX_HUNT;
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/serial_rx_idle_det.sv
module serial_rx_idle_det
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 4,
  parameter int unsigned OVERSAMPLE    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_s_i,
  input  logic byte_i,
  output logic idle_o
);

  localparam int unsigned CHAR_CLKS = char_clks(CLKS_PER_TICK, OVERSAMPLE);
  localparam int unsigned QW        = $clog2(CHAR_CLKS);
  localparam logic [QW-1:0] CHAR_LAST = QW'(CHAR_CLKS - 1);

  logic          armed;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed  <= 1'b0;
      quiet  <= '0;
      idle_o <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (byte_i) begin
        armed <= 1'b1;
        quiet <= '0;
      end else if (armed) begin
        if (!rx_s_i) begin
          quiet <= '0;
        end else if (quiet == CHAR_LAST) begin
          idle_o <= 1'b1;
          armed  <= 1'b0;
          quiet  <= '0;
        end else begin
          quiet <= quiet + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/serial_rx_idle.sv
module serial_rx_idle
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 4,
  parameter int unsigned OVERSAMPLE    = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 rx_frame_err_o,
  output logic                 rx_idle_o
);

  // named internal events, used by the bound checker
  logic rx_sync;
  logic start_glitch;
  logic byte_done;
  logic stop_low;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  serial_rx_frame #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .OVERSAMPLE   (OVERSAMPLE)
  ) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rx_s_i        (rx_sync),
    .data_o        (rx_data_o),
    .valid_o       (rx_valid_o),
    .frame_err_o   (rx_frame_err_o),
    .start_glitch_o(start_glitch),
    .byte_done_o   (byte_done),
    .stop_low_o    (stop_low)
  );

  serial_rx_idle_det #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .OVERSAMPLE   (OVERSAMPLE)
  ) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_s_i(rx_sync),
    .byte_i(rx_valid_o),
    .idle_o(rx_idle_o)
  );

endmodule

// File: rtl/serial_rx_idle_chk.sv
module serial_rx_idle_chk
  import serial_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 4,
  parameter int unsigned OVERSAMPLE    = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_sync,
  input logic start_glitch,
  input logic byte_done,
  input logic stop_low,
  input logic rx_valid_o,
  input logic rx_frame_err_o,
  input logic rx_idle_o
);

  localparam int unsigned CHAR_CLKS = char_clks(CLKS_PER_TICK, OVERSAMPLE);
  localparam int unsigned QW        = $clog2(CHAR_CLKS + 1);
  localparam logic [QW-1:0] CHAR_SAT = QW'(CHAR_CLKS);

  logic          seen_byte;
  logic [QW-1:0] high_run;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      seen_byte <= 1'b0;
      high_run  <= '0;
    end else begin
      if (rx_valid_o)     seen_byte <= 1'b1;
      else if (rx_idle_o) seen_byte <= 1'b0;
      if (!rx_sync)                high_run <= '0;
      else if (high_run != CHAR_SAT) high_run <= high_run + 1'b1;
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_strobe_follows_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> rx_valid_o);

  p_glitch_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_glitch |=> !rx_valid_o);

  p_err_qualified_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_err_o |-> rx_valid_o);

  p_err_matches_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> (rx_frame_err_o == $past(stop_low)));

  p_idle_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_idle_o |=> !rx_idle_o);

  p_idle_needs_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_idle_o |-> seen_byte);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_idle_o |-> (high_run >= CHAR_SAT));

endmodule

bind serial_rx_idle serial_rx_idle_chk #(
  .CLKS_PER_TICK(CLKS_PER_TICK),
  .OVERSAMPLE   (OVERSAMPLE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_sync       (rx_sync),
  .start_glitch  (start_glitch),
  .byte_done     (byte_done),
  .stop_low      (stop_low),
  .rx_valid_o    (rx_valid_o),
  .rx_frame_err_o(rx_frame_err_o),
  .rx_idle_o     (rx_idle_o)
);

// File: tb/serial_rx_idle_tb_top.sv
`timescale 1ns/1ps
module serial_rx_idle_tb_top;

  localparam int DIV  = 2;
  localparam int OSR  = 16;
  localparam int BITP = DIV * OSR;   // R10-style scaling: all timing from divisor
  localparam int HALF = BITP / 2;
  localparam int CHR  = BITP * 10;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ferr, rx_idle;

  always #2.5 clk = ~clk;

  serial_rx_idle #(.CLKS_PER_TICK(DIV), .OVERSAMPLE(OSR)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rx_i          (rx),
    .rx_data_o     (rx_data),
    .rx_valid_o    (rx_valid),
    .rx_frame_err_o(rx_ferr),
    .rx_idle_o     (rx_idle)
  );

  typedef struct {
    int         due;
    logic [7:0] d;
    logic       fe;
  } exp_t;

  exp_t exp_q[$];
  logic line_q[$];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  int   last_low = 0;
  int   arm_at = 0;
  bit   fired = 1'b1;
  int   idle_seen = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at edge %0d", req, what, act, expv, cyc);
    end
  endtask

  // record the driven line at each edge
  always @(posedge clk) begin
    cyc++;
    line_q.push_back(rx);
    if (line_q.size() > 3) void'(line_q.pop_front());
  end

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_idle, exp_valid;
      int base;
      if (line_q.size() == 3 && line_q[0] == 1'b0) last_low = cyc;
      base = (arm_at > last_low) ? arm_at : last_low;
      exp_idle = !fired && (cyc == base + CHR);
      if (exp_idle) fired = 1'b1;
      if (rx_idle) idle_seen++;
      check(rx_idle == exp_idle, "R6", "idle pulse", rx_idle, exp_idle);
      exp_valid = (exp_q.size() > 0) && (exp_q[0].due == cyc);
      check(rx_valid == exp_valid, "R2", "valid strobe (R3 single cycle)", rx_valid, exp_valid);
      if (exp_valid) begin
        check(rx_data == exp_q[0].d, "R2", "data", rx_data, exp_q[0].d);
        check(rx_ferr == exp_q[0].fe, "R5", "frame error", rx_ferr, exp_q[0].fe);
        void'(exp_q.pop_front());
        arm_at = cyc + 1;
        fired  = 1'b0;
      end else begin
        check(rx_ferr == 1'b0, "R5", "frame error outside strobe", rx_ferr, 0);
      end
    end
  end

  // caller stands at a negedge; returns at a negedge with line high
  task automatic send_byte(input logic [7:0] d, input bit stop_ok);
    exp_t e;
    e.due = cyc + 3 + HALF + 9 * BITP;
    e.d   = d;
    e.fe  = !stop_ok;
    exp_q.push_back(e);
    rx = 1'b0;
    repeat (BITP) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BITP) @(negedge clk);
    end
    rx = stop_ok;
    repeat (BITP) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic glitch();
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int base_idle;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!rx_valid && !rx_ferr && !rx_idle, "R1", "outputs in reset",
          {rx_valid, rx_ferr, rx_idle}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rx_valid && !rx_ferr && !rx_idle, "R1", "outputs after reset",
          {rx_valid, rx_ferr, rx_idle}, 0);

    // R7: no idle before any byte
    repeat (2 * CHR) @(negedge clk);
    check(idle_seen == 0, "R7", "idle before first byte", idle_seen, 0);

    // R2 / R6: single byte then quiet
    send_byte(8'hA5, 1'b1);
    repeat (CHR + 2 * BITP) @(negedge clk);
    check(idle_seen == 1, "R6", "idle after single byte", idle_seen, 1);

    // R9: back-to-back burst, one idle only
    send_byte(8'h3C, 1'b1);
    send_byte(8'hFF, 1'b1);
    send_byte(8'h00, 1'b1);
    repeat (CHR + 2 * BITP) @(negedge clk);
    check(idle_seen == 2, "R9", "single idle after burst", idle_seen, 2);

    // R7: stays quiet, no second idle
    repeat (2 * CHR) @(negedge clk);
    check(idle_seen == 2, "R7", "no repeat idle", idle_seen, 2);

    // R5: stop bit low, byte still delivered
    send_byte(8'h5A, 1'b0);
    repeat (CHR + 3 * BITP) @(negedge clk);
    check(idle_seen == 3, "R5", "idle after framing error byte", idle_seen, 3);

    // R4: glitch while unarmed gives no byte and no idle
    glitch();
    repeat (CHR + 2 * BITP) @(negedge clk);
    check(idle_seen == 3, "R4", "glitch while unarmed", idle_seen, 3);

    // R8: glitch during countdown restarts it; R4 no byte from it
    send_byte(8'h81, 1'b1);
    repeat (CHR / 2) @(negedge clk);
    base_idle = idle_seen;
    glitch();
    repeat (CHR / 2 + 2 * BITP) @(negedge clk);
    check(idle_seen == base_idle, "R8", "countdown restarted", idle_seen, base_idle);
    repeat (CHR) @(negedge clk);
    check(idle_seen == base_idle + 1, "R8", "idle after restart", idle_seen, base_idle + 1);

    send_byte(8'h01, 1'b1);
    repeat (CHR + 2 * BITP) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all bytes delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule